// File: doc/BRIEF.md
# Three-Channel Programmable Down-Counter Timer

This block holds three independent 16-bit down counters behind a small byte-wide register interface. Software writes a control byte to set a channel's byte access style, a stored mode number and binary or BCD arithmetic. It then loads a start count. Each channel steps down once per rising edge of its own tick input, but only while that channel's enable input is high. When a step lands on zero, the channel's terminal output goes high and can serve as an interrupt request.

The count can be read while it runs, and reading never changes it. To get a coherent 16-bit value, software can freeze a snapshot into a hold register and read that instead. A separate multi-channel command captures the snapshot, a status byte, or both, for any subset of channels. Reads and writes of a channel keep separate byte pointers, so the two directions can be interleaved. The data bus is split into an input byte and an output byte; pad drivers sit outside the block.

Top module: `ptmr_top`

## Requirements
- R1: After reset every terminal output is low, every count is 0000h, and every channel uses low-then-high access, binary arithmetic and mode 0, with its not-loaded flag set.
- R2: bus_addr 0, 1 and 2 reach channels 0, 1 and 2 and address 3 reaches the control register. An access touches only the addressed channel.
- R3: Control byte layout: [7:6] is the channel (11 means multi-channel command), [5:4] is the access style (00 snapshot, 01 low byte only, 10 high byte only, 11 low then high), [3:1] is the stored mode and [0] selects BCD. A control byte with a non-00 access style drives the terminal output low, sets the not-loaded flag, resets both byte pointers, drops any held snapshot or status, and stops counting until a count is loaded.
- R4: Count loading follows the access style. Low-only loads {00h, byte}. High-only loads {byte, 00h}. Low-then-high stores the low byte, drops the terminal output and pauses counting, and the high byte then loads the full count. A load clears the not-loaded flag and arms counting.
- R5: A tick rising edge with the enable high steps an armed count down by one, and the change is visible two system clock edges after the tick's rise is first sampled. With the enable low, the count holds.
- R6: A binary count wraps from 0000h to FFFFh. A BCD count steps each 4-bit digit through 9..0 with a borrow and wraps from 0000 to 9999.
- R7: The terminal output rises when a step reaches zero. It stays high through later steps until the next count byte or mode-setting control byte is written.
- R8: A read returns a byte of the live count (low byte for low-only, high byte for high-only, alternating low then high for low-then-high) and leaves the count unchanged.
- R9: A snapshot command copies the count into a hold register. Reads return the held bytes until the final byte has been read, while the live count keeps running. A second snapshot command before that is ignored.
- R10: If a snapshot command and a step happen on the same clock edge, the hold register gets the value before the step.
- R11: The read and write byte pointers are separate, so interleaving low/high reads and writes on one channel keeps each sequence intact.
- R12: Multi-channel command: bit 5 requests a count snapshot, bit 4 requests a status snapshot, and bits 1, 2 and 3 select channels 0, 1 and 2. The status byte is {out, not-loaded, access[1:0], mode[2:0], bcd}. A held status byte is read first, then the held count.
- R13: With bus_sel low, read and write strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Block select, qualifies both strobes |
| bus_rd | input | 1 | Read strobe, one clock per byte |
| bus_wr | input | 1 | Write strobe, one clock per byte |
| bus_addr | input | 2 | Channel (0-2) or control register (3) |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for the addressed channel |
| tmr_clk | input | NUM_CH | Per-channel tick inputs |
| tmr_gate | input | NUM_CH | Per-channel count enables |
| tmr_out | output | NUM_CH | Per-channel terminal outputs |

## Verification
A snapshot command and a counter step can land on the same system clock edge, and the result depends on which value is captured. The bench raises a channel's tick one cycle early so that the step falls on exactly the edge where the snapshot byte is written. It then expects the held bytes to show the pre-step count and the live bytes to show one less. A second collision is a write of the low count byte while a held snapshot is still being read out. It is judged by checking that the held high byte and the newly loaded count each come back unmixed.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DIGITS = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_LOHI = 2'b11
    } acc_e;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  hold;
        logic              hold_v;
        logic [BYTE_W-1:0] sta;
        logic              sta_v;
        logic [BYTE_W-1:0] lo_pend;
        logic              wr_hi;
        logic              rd_hi;
        acc_e              acc;
        logic [2:0]        mode;
        logic              bcd;
        logic              armed;
        logic              unloaded;
        logic              out;
    } chan_st_t;

    // One step down in binary or per-digit BCD with borrow.
    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v,
                                                   input logic bcd);
        logic [CNT_W-1:0] r;
        logic             brw;
        r   = v;
        brw = 1'b1;
        if (!bcd) begin
            r = v - 1'b1;
        end else begin
            for (int i = 0; i < int'(DIGITS); i++) begin
                if (brw) begin
                    if (r[i*4 +: 4] == 4'd0) begin
                        r[i*4 +: 4] = 4'd9;
                    end else begin
                        r[i*4 +: 4] = r[i*4 +: 4] - 4'd1;
                        brw = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ptmr_edge.sv
module ptmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic gate_in,
    output logic step
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic g;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = tick_in;
        st_d.s2 = st_q.s1;
        st_d.g  = gate_in;
        step    = st_q.s1 && !st_q.s2 && st_q.g;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ptmr_decode.sv
module ptmr_decode #(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [NUM_CH-1:0] ctl_wr,
    output logic [NUM_CH-1:0] cnt_wr,
    output logic [NUM_CH-1:0] cnt_rd,
    output logic [NUM_CH-1:0] rb_cnt,
    output logic [NUM_CH-1:0] rb_sta
);
    logic ctl_hit;
    logic multi_hit;

    assign ctl_hit   = bus_sel && bus_wr && (bus_addr == 2'd3);
    assign multi_hit = ctl_hit && (bus_wdata[7:6] == 2'b11);

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
        assign ctl_wr[i] = ctl_hit && (bus_wdata[7:6] == 2'(i));
        assign cnt_wr[i] = bus_sel && bus_wr && (bus_addr == 2'(i));
        assign cnt_rd[i] = bus_sel && bus_rd && (bus_addr == 2'(i));
        assign rb_cnt[i] = multi_hit && bus_wdata[1+i] && bus_wdata[5];
        assign rb_sta[i] = multi_hit && bus_wdata[1+i] && bus_wdata[4];
    end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ctl_wr,
    input  logic              cnt_wr,
    input  logic              cnt_rd,
    input  logic              rb_cnt,
    input  logic              rb_sta,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              out
);
    chan_st_t st_d, st_q;

    logic             snap_req;
    logic             mode_wr;
    logic             sel_hi;
    logic [CNT_W-1:0] src;
    logic [BYTE_W-1:0] sta_now;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        st_d     = st_q;
        snap_req = (ctl_wr && (wdata[5:4] == 2'b00)) || rb_cnt;
        mode_wr  = ctl_wr && (wdata[5:4] != 2'b00);
        sta_now  = {st_q.out, st_q.unloaded, st_q.acc, st_q.mode, st_q.bcd};
        src      = st_q.hold_v ? st_q.hold : st_q.count;
        sel_hi   = (st_q.acc == ACC_HI) || ((st_q.acc == ACC_LOHI) && st_q.rd_hi);
        rdata    = st_q.sta_v ? st_q.sta : (sel_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0]);
        stepped  = step_down(st_q.count, st_q.bcd);

        // counting
        if (step && st_q.armed) begin
            st_d.count = stepped;
            if (stepped == '0) st_d.out = 1'b1;
        end

        // snapshots take the pre-step value
        if (snap_req && !st_q.hold_v) begin
            st_d.hold   = st_q.count;
            st_d.hold_v = 1'b1;
        end
        if (rb_sta && !st_q.sta_v) begin
            st_d.sta   = sta_now;
            st_d.sta_v = 1'b1;
        end

        // read byte sequencing
        if (cnt_rd) begin
            if (st_q.sta_v) begin
                st_d.sta_v = 1'b0;
            end else if (st_q.acc == ACC_LOHI) begin
                st_d.rd_hi = !st_q.rd_hi;
                if (st_q.rd_hi) st_d.hold_v = 1'b0;
            end else begin
                st_d.hold_v = 1'b0;
            end
        end

        // count loading
        if (cnt_wr) begin
            st_d.out = 1'b0;
            unique case (st_q.acc)
                ACC_LO: begin
                    st_d.count    = {{BYTE_W{1'b0}}, wdata};
                    st_d.armed    = 1'b1;
                    st_d.unloaded = 1'b0;
                end
                ACC_HI: begin
                    st_d.count    = {wdata, {BYTE_W{1'b0}}};
                    st_d.armed    = 1'b1;
                    st_d.unloaded = 1'b0;
                end
                default: begin
                    if (!st_q.wr_hi) begin
                        st_d.lo_pend = wdata;
                        st_d.wr_hi   = 1'b1;
                        st_d.armed   = 1'b0;
                    end else begin
                        st_d.count    = {wdata, st_q.lo_pend};
                        st_d.wr_hi    = 1'b0;
                        st_d.armed    = 1'b1;
                        st_d.unloaded = 1'b0;
                    end
                end
            endcase
        end

        // mode setting
        if (mode_wr) begin
            st_d.acc      = acc_e'(wdata[5:4]);
            st_d.mode     = wdata[3:1];
            st_d.bcd      = wdata[0];
            st_d.out      = 1'b0;
            st_d.armed    = 1'b0;
            st_d.unloaded = 1'b1;
            st_d.wr_hi    = 1'b0;
            st_d.rd_hi    = 1'b0;
            st_d.hold_v   = 1'b0;
            st_d.sta_v    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.acc      <= ACC_LOHI;
            st_q.unloaded <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out = st_q.out;

    AST_MODE_WR_DROPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !out); // R3
    AST_GATED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.armed && !cnt_wr && !mode_wr && !st_q.bcd)
        |=> (st_q.count == $past(st_q.count) - 16'd1)); // R5
    AST_READ_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !cnt_wr && !mode_wr) |=> $stable(st_q.count)); // R8
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold_v && !mode_wr) |=> (st_q.hold == $past(st_q.hold))); // R9
    AST_OUT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out) |-> (st_q.count == '0)); // R7
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_CH-1:0] tmr_clk,
    input  logic [NUM_CH-1:0] tmr_gate,
    output logic [NUM_CH-1:0] tmr_out
);
    logic [NUM_CH-1:0] ctl_wr, cnt_wr, cnt_rd, rb_cnt, rb_sta, step;
    logic [7:0]        ch_rdata [NUM_CH];

    ptmr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctl_wr    (ctl_wr),
        .cnt_wr    (cnt_wr),
        .cnt_rd    (cnt_rd),
        .rb_cnt    (rb_cnt),
        .rb_sta    (rb_sta)
    );

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_chan
        ptmr_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_in (tmr_clk[i]),
            .gate_in (tmr_gate[i]),
            .step    (step[i])
        );
        ptmr_channel u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (step[i]),
            .ctl_wr (ctl_wr[i]),
            .cnt_wr (cnt_wr[i]),
            .cnt_rd (cnt_rd[i]),
            .rb_cnt (rb_cnt[i]),
            .rb_sta (rb_sta[i]),
            .wdata  (bus_wdata),
            .rdata  (ch_rdata[i]),
            .out    (tmr_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            if (bus_addr == 2'(i)) bus_rdata = ch_rdata[i];
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_wr, cnt_rd, ctl_wr})); // R2
    AST_NO_SEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> ({cnt_wr, cnt_rd, ctl_wr, rb_cnt, rb_sta} == '0)); // R13
endmodule

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] tmr_clk = '0, tmr_gate = 3'b111;
    logic [2:0] tmr_out;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_cnt [3];
    logic        m_bcd [3];

    always #10 clk = ~clk;

    ptmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_clk(tmr_clk), .tmr_gate(tmr_gate), .tmr_out(tmr_out)
    );

    function automatic logic [15:0] mdec(input logic [15:0] v, input logic bcd);
        int n;
        if (!bcd) return v - 16'd1;
        n = v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
        n = (n + 9999) % 10000;
        return {4'(n/1000), 4'((n/100)%10), 4'((n/10)%10), 4'(n%10)};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
        #5 d = bus_rdata;
        @(negedge clk); bus_sel = 0; bus_rd = 0;
    endtask

    task automatic rd16(input int ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        brd(2'(ch), lo); brd(2'(ch), hi);
        v = {hi, lo};
    endtask

    task automatic load16(input int ch, input logic [15:0] v);
        bwr(2'(ch), v[7:0]); bwr(2'(ch), v[15:8]);
        m_cnt[ch] = v;
    endtask

    task automatic tick(input logic [2:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tmr_clk = tmr_clk | mask;
            @(negedge clk);
            @(negedge clk); tmr_clk = tmr_clk & ~mask;
            @(negedge clk);
            for (int c = 0; c < 3; c++)
                if (mask[c] && tmr_gate[c]) m_cnt[c] = mdec(m_cnt[c], m_bcd[c]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        for (int c = 0; c < 3; c++) begin m_cnt[c] = 0; m_bcd[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 outputs low", {13'd0, tmr_out}, 16'h0000);
        bwr(3, 8'hD2);
        brd(0, b); chk("R1 R12 reset status ch0", {8'd0, b}, 16'h0070);
        rd16(0, v); chk("R1 reset count", v, 16'h0000);

        // R3 R4 R8 load and live read
        bwr(3, 8'h30); load16(0, 16'h0105);
        rd16(0, v); chk("R4 R8 loaded count", v, m_cnt[0]);
        rd16(0, v); chk("R8 reread unchanged", v, 16'h0105);
        tick(3'b001, 3);
        rd16(0, v); chk("R5 three steps", v, m_cnt[0]);
        tmr_gate[0] = 0; tick(3'b001, 2); tmr_gate[0] = 1;
        rd16(0, v); chk("R5 gate low holds", v, 16'h0102);

        // R7 R6 terminal and wrap
        load16(0, 16'h0002);
        tick(3'b001, 1); chk("R7 out low at 1", {15'd0, tmr_out[0]}, 16'h0000);
        tick(3'b001, 1); chk("R7 out high at 0", {15'd0, tmr_out[0]}, 16'h0001);
        tick(3'b001, 1); chk("R7 out stays high", {15'd0, tmr_out[0]}, 16'h0001);
        rd16(0, v); chk("R6 binary wrap", v, 16'hFFFF);
        bwr(0, 8'h30); chk("R4 low byte drops out", {15'd0, tmr_out[0]}, 16'h0000);
        bwr(0, 8'h03); m_cnt[0] = 16'h0330;

        // R9 snapshot
        bwr(3, 8'h00); tick(3'b001, 5); bwr(3, 8'h00);
        rd16(0, v); chk("R9 held value", v, 16'h0330);
        rd16(0, v); chk("R9 live after hold", v, m_cnt[0]);

        // R3 R6 BCD on ch1
        bwr(3, 8'h71); m_bcd[1] = 1;
        bwr(3, 8'hD4); brd(1, b); chk("R3 R12 unloaded status ch1", {8'd0, b}, 16'h0071);
        load16(1, 16'h1000); tick(3'b010, 1);
        rd16(1, v); chk("R6 BCD borrow", v, 16'h0999);
        load16(1, 16'h0000); tick(3'b010, 1);
        rd16(1, v); chk("R6 BCD wrap", v, 16'h9999);
        chk("R7 wrap no out", {15'd0, tmr_out[1]}, 16'h0000);

        // R4 R12 access styles on ch2
        bwr(3, 8'h94); bwr(2, 8'h07);
        brd(2, b); chk("R4 low only", {8'd0, b}, 16'h0007);
        bwr(3, 8'hF8);
        brd(2, b); chk("R12 status first", {8'd0, b}, 16'h0014);
        brd(2, b); chk("R12 count after status", {8'd0, b}, 16'h0007);
        bwr(3, 8'hA0); bwr(2, 8'h12);
        brd(2, b); chk("R4 high only", {8'd0, b}, 16'h0012);
        tick(3'b100, 2);
        brd(2, b); chk("R4 high only after steps", {8'd0, b}, 16'h0011);

        // R11 interleave
        bwr(3, 8'hB0); load16(2, 16'h0450); bwr(3, 8'h80);
        brd(2, b); chk("R11 held low", {8'd0, b}, 16'h0050);
        bwr(2, 8'h22);
        brd(2, b); chk("R11 held high", {8'd0, b}, 16'h0004);
        bwr(2, 8'h06);
        rd16(2, v); chk("R11 new load", v, 16'h0622);

        // R10 snapshot on the stepping edge
        bwr(3, 8'h30); load16(0, 16'h0010);
        @(negedge clk); tmr_clk[0] = 1;
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 3; bus_wdata = 8'h00;
        @(negedge clk); bus_sel = 0; bus_wr = 0; tmr_clk[0] = 0;
        @(negedge clk);
        rd16(0, v); chk("R10 pre-step held", v, 16'h0010);
        rd16(0, v); chk("R10 live stepped", v, 16'h000F);

        // R13 strobes without select
        @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 8'hFF;
        @(negedge clk); bus_addr = 3; bus_wdata = 8'h00;
        @(negedge clk); bus_wr = 0;
        tick(3'b001, 1);
        rd16(0, v); chk("R13 unselected ignored", v, 16'h000E);
        rd16(1, v); chk("R2 ch1 untouched", v, 16'h9999);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule